// File: doc/BRIEF.md
# SYSREF Quarter-Period Edge Classifier and Phase Monitor

The block receives, once per logic clock period, a four-bit snapshot of the SYSREF input. The snapshot is taken at four sampling points in one device clock period. In time order these points are the early falling edge, the falling edge, the early rising edge and the rising edge. The four bits arrive already synchronised into the logic clock domain. The block finds the first rising SYSREF transition in each period and assigns it to one of four quarter-period phases. It then sends a one-cycle strobe and a 2-bit phase code to the downstream alignment logic.

When monitoring is enabled, the block keeps a sticky flag and an 8-bit saturating occurrence counter for each phase. Two more saturating counters record how many events were aimed at the earlier or the later of two reference rising edges. That choice depends on a tolerance-window selection and an alignment offset. A clear input resets all of these statistics and nothing else. A select input picks one counter for readback.

The transition tracker is a two-state machine. SR_LOW means the last sample of the previous period was 0. SR_HIGH means it was 1. The machine leaves reset in SR_HIGH. Its transitions are LOW_TO_HIGH and HIGH_HOLD (last sample is 1), and HIGH_TO_LOW and LOW_HOLD (last sample is 0). An event can be found in either state: in SR_LOW the period starts from a 0, and in SR_HIGH a rise is counted only after a 0 inside the period.

Top module: `sysref_phase_mon`

## Requirements
- R1: Snapshot bits are `smp[0]`=early falling, `smp[1]`=falling, `smp[2]`=early rising, `smp[3]`=rising. The phase code is defined by where the rise happens:
  - Rise between `smp[0]` and `smp[1]`: phase 1, code 0.
  - Rise between `smp[1]` and `smp[2]`: phase 2, code 1.
  - Rise between `smp[2]` and `smp[3]`: phase 3, code 2.
  - Rise between the previous period's `smp[3]` and `smp[0]`: phase 4, code 3.
- R2: Only the first 0-to-1 change in the five-bit sequence {previous `smp[3]`, `smp[0..3]`} is an event. A SYSREF that stays high creates no further events. After reset the previous sample counts as 1.
- R3: `evt_vld` is high for exactly the cycle after the clock edge that captured the snapshot, with `evt_phase` valid. This happens whether or not `mon_en` is set.
- R4: After reset, all flags and counters are zero.
- R5: A phase's flag (`flags[code]`) sets on a monitored event of that phase. It stays set until a clear.
- R6: Each monitored event increments its phase counter by one. The counter stops at 255 and does not wrap.
- R7: Each monitored event increments exactly one alignment counter, early or late. `win[1]`=0 selects early and `win[1]`=1 selects late. `ofs`=1 moves early to late, `ofs`=2 moves late to early, and `ofs`=0 or 3 changes nothing.
- R8: `clr`=1 zeroes all flags and counters at the next edge. It has priority over an event in the same cycle.
- R9: With `mon_en`=0, flags and counters hold their values.
- R10: `rd_data` shows counter `rd_sel` combinationally. Selections 0–3 are phases 1–4, 4 is early alignment, 5 is late alignment, and 6–7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock, one snapshot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| smp | input | 4 | SYSREF snapshot, bit 0 earliest |
| mon_en | input | 1 | Enables statistics update |
| clr | input | 1 | Clears flags and counters |
| win | input | 2 | Tolerance window selection |
| ofs | input | 2 | Alignment offset: 0 none, 1 later, 2 earlier |
| rd_sel | input | 3 | Counter readback select |
| evt_vld | output | 1 | One-cycle event strobe |
| evt_phase | output | 2 | Phase code of the event |
| flags | output | 4 | Sticky per-phase flags |
| rd_data | output | 8 | Selected counter value |

## Verification
Single-edge snapshots that start from low put a rise at each of the four positions in turn. These patterns tell apart all four phase codes, including the phase-4 rise that spans the period boundary. Held-high and double-pulse patterns, together with a rise that follows a 0 in the SR_HIGH state, separate "first rise only" from "any high bit". A long run of phase-1 pulses drives a counter past 255. Events that coincide with a clear, or that arrive while monitoring is off, show that clear takes priority and that statistics freeze. Sweeping all window and offset combinations shows which alignment counter moves.

// File: rtl/sysref_mon_pkg.sv
package sysref_mon_pkg;
    localparam int NUM_PH  = 4;
    localparam int CNT_W   = 8;
    localparam int NUM_CNT = NUM_PH + 2;

    typedef enum logic {
        SR_LOW  = 1'b0,
        SR_HIGH = 1'b1
    } lvl_state_t;

    typedef enum logic [1:0] {
        OFS_NONE    = 2'd0,
        OFS_LATER   = 2'd1,
        OFS_EARLIER = 2'd2,
        OFS_RSVD    = 2'd3
    } ofs_t;
endpackage

// File: rtl/sysref_sat_cnt.sv
module sysref_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc && cnt != MAXV)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sysref_edge_classifier.sv
module sysref_edge_classifier
    import sysref_mon_pkg::*;
#(
    parameter int NS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] smp,
    output logic          det,
    output logic [1:0]    det_code,
    output logic          evt_vld,
    output logic [1:0]    evt_phase
);
    lvl_state_t state, state_nxt;

    // Find the first 0->1 step in {prev, smp[0..NS-1]}.
    // Position 0 (prev->smp[0]) maps to code 3; position k maps to code k-1.
    function automatic logic [2:0] first_rise(input logic prev, input logic [NS-1:0] s);
        logic       last;
        logic [2:0] res;
        res  = 3'b000;
        last = prev;
        for (int i = 0; i < NS; i++) begin
            if (!res[2] && !last && s[i])
                res = {1'b1, (i == 0) ? 2'd3 : 2'(i - 1)};
            last = s[i];
        end
        return res;
    endfunction

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SR_HIGH;
        else
            state <= state_nxt;
    end

    // Next state and detection
    always_comb begin
        logic [2:0] r;
        r = 3'b000;
        state_nxt = state;
        unique case (state)
            SR_LOW: begin
                r = first_rise(1'b0, smp);
                state_nxt = smp[NS-1] ? SR_HIGH : SR_LOW;   // LOW_TO_HIGH / LOW_HOLD
            end
            SR_HIGH: begin
                r = first_rise(1'b1, smp);
                state_nxt = smp[NS-1] ? SR_HIGH : SR_LOW;   // HIGH_HOLD / HIGH_TO_LOW
            end
        endcase
        det      = r[2];
        det_code = r[1:0];
    end

    // Registered strobe outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_vld   <= 1'b0;
            evt_phase <= 2'd0;
        end else begin
            evt_vld   <= det;
            evt_phase <= det ? det_code : evt_phase;
        end
    end
endmodule

// File: rtl/sysref_phase_stats.sv
module sysref_phase_stats
    import sysref_mon_pkg::*;
#(
    parameter int NP = NUM_PH,
    parameter int W  = CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                det,
    input  logic [1:0]          det_code,
    input  logic                mon_en,
    input  logic                clr,
    input  logic [1:0]          win,
    input  logic [1:0]          ofs,
    output logic [NP-1:0]       flags,
    output logic [NP+1:0][W-1:0] cnts
);
    localparam int IDX_EARLY = NP;
    localparam int IDX_LATE  = NP + 1;

    logic          upd;
    logic          tgt_late;
    logic [NP+1:0] inc;

    assign upd = det && mon_en;

    always_comb begin
        unique case (ofs_t'(ofs))
            OFS_LATER:   tgt_late = 1'b1;
            OFS_EARLIER: tgt_late = 1'b0;
            OFS_NONE,
            OFS_RSVD:    tgt_late = win[1];
        endcase
    end

    genvar g;
    generate
        for (g = 0; g < NP; g++) begin : g_ph
            assign inc[g] = upd && (det_code == 2'(g));

            always_ff @(posedge clk) begin
                if (!rst_n || clr)
                    flags[g] <= 1'b0;
                else if (inc[g])
                    flags[g] <= 1'b1;
            end
        end
    endgenerate

    assign inc[IDX_EARLY] = upd && !tgt_late;
    assign inc[IDX_LATE]  = upd &&  tgt_late;

    generate
        for (g = 0; g < NP + 2; g++) begin : g_cnt
            sysref_sat_cnt #(.W(W)) u_cnt (
                .clk  (clk),
                .rst_n(rst_n),
                .clr  (clr),
                .inc  (inc[g]),
                .cnt  (cnts[g])
            );
        end
    endgenerate
endmodule

// File: rtl/sysref_phase_mon.sv
module sysref_phase_mon
    import sysref_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       smp,
    input  logic             mon_en,
    input  logic             clr,
    input  logic [1:0]       win,
    input  logic [1:0]       ofs,
    input  logic [2:0]       rd_sel,
    output logic             evt_vld,
    output logic [1:0]       evt_phase,
    output logic [NUM_PH-1:0] flags,
    output logic [CNT_W-1:0] rd_data
);
    logic                         det;
    logic [1:0]                   det_code;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnts;

    sysref_edge_classifier #(.NS(4)) u_cls (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp      (smp),
        .det      (det),
        .det_code (det_code),
        .evt_vld  (evt_vld),
        .evt_phase(evt_phase)
    );

    sysref_phase_stats #(.NP(NUM_PH), .W(CNT_W)) u_stats (
        .clk     (clk),
        .rst_n   (rst_n),
        .det     (det),
        .det_code(det_code),
        .mon_en  (mon_en),
        .clr     (clr),
        .win     (win),
        .ofs     (ofs),
        .flags   (flags),
        .cnts    (cnts)
    );

    always_comb begin
        if (int'(rd_sel) < NUM_CNT)
            rd_data = cnts[rd_sel];
        else
            rd_data = '0;
    end
endmodule

// File: rtl/sysref_mon_chk.sv
module sysref_mon_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] smp,
    input logic       mon_en,
    input logic       clr,
    input logic       evt_vld,
    input logic [1:0] evt_phase,
    input logic [3:0] flags
);
    // An event needs a high bit in the previous snapshot (R2)
    assert_evt_needs_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_vld |-> $past(smp) != 4'b0000);

    // A phase-4 event needs the earliest sample high (R1)
    assert_phase4_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && evt_phase == 2'd3) |-> $past(smp[0]));

    // Flags never drop without a clear (R5)
    assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));

    // Clear zeroes the flags (R8)
    assert_clear_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> flags == 4'b0000);

    // Monitoring off freezes the flags (R9)
    assert_disabled_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_en && !clr) |=> $stable(flags));

    // A monitored event marks its phase (R5)
    assert_event_marks_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && $past(mon_en) && !$past(clr)) |-> flags[evt_phase]);
endmodule

bind sysref_phase_mon sysref_mon_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp      (smp),
    .mon_en   (mon_en),
    .clr      (clr),
    .evt_vld  (evt_vld),
    .evt_phase(evt_phase),
    .flags    (flags)
);

// File: tb/sim_sysref_phase_mon.sv
`timescale 1ns/1ps
module sim_sysref_phase_mon;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] smp = 4'b0;
    logic       mon_en = 1'b0;
    logic       clr = 1'b0;
    logic [1:0] win = 2'd0;
    logic [1:0] ofs = 2'd0;
    logic [2:0] rd_sel = 3'd0;
    logic       evt_vld;
    logic [1:0] evt_phase;
    logic [3:0] flags;
    logic [7:0] rd_data;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R4";

    // behavioural reference state
    int       m_cnt[6];
    bit [3:0] m_flags;
    bit       m_prev;
    bit       m_evt;
    int       m_ph;
    int       m_rot;

    always #2 clk = ~clk;   // 250 MHz

    sysref_phase_mon u0 (
        .clk(clk), .rst_n(rst_n), .smp(smp), .mon_en(mon_en), .clr(clr),
        .win(win), .ofs(ofs), .rd_sel(rd_sel), .evt_vld(evt_vld),
        .evt_phase(evt_phase), .flags(flags), .rd_data(rd_data)
    );

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        foreach (m_cnt[i]) m_cnt[i] = 0;
        m_flags = 0; m_prev = 1; m_evt = 0; m_ph = 0;
    endtask

    task automatic model_step();
        bit seq[5];
        bit found;
        int pos;
        found = 0; pos = 0;
        seq[0] = m_prev;
        for (int i = 0; i < 4; i++) seq[i+1] = smp[i];
        for (int i = 1; i < 5; i++)
            if (!found && !seq[i-1] && seq[i]) begin found = 1; pos = i; end
        m_prev = smp[3];
        m_evt = found;
        if (found) m_ph = (pos == 1) ? 3 : pos - 2;
        if (clr) begin
            foreach (m_cnt[i]) m_cnt[i] = 0;
            m_flags = 0;
        end else if (mon_en && found) begin
            bit late;
            m_flags[m_ph] = 1;
            if (m_cnt[m_ph] < 255) m_cnt[m_ph]++;
            late = win[1];
            if (ofs == 2'd1) late = 1;
            else if (ofs == 2'd2) late = 0;
            if (late) begin if (m_cnt[5] < 255) m_cnt[5]++; end
            else      begin if (m_cnt[4] < 255) m_cnt[4]++; end
        end
    endtask

    function automatic int exp_rd(int sel);
        return (sel < 6) ? m_cnt[sel] : 0;
    endfunction

    task automatic compare();
        chk("evt_vld", evt_vld, m_evt);
        if (m_evt) chk("evt_phase", evt_phase, m_ph);
        chk("flags", flags, m_flags);
        chk("rd_data", rd_data, exp_rd(rd_sel));
    endtask

    // one cycle: inputs driven at negedge, compared at the next negedge
    task automatic step(input logic [3:0] s, input logic e, input logic c);
        smp = s; mon_en = e; clr = c;
        rd_sel = 3'(m_rot % 8); m_rot++;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    initial begin
        model_reset();
        m_rot = 0;
        repeat (3) @(negedge clk);
        // R4: reset state, all readback selections
        cur_req = "R4";
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i);
            #0.1;
            chk("rd_data after reset", rd_data, 0);
        end
        chk("flags after reset", flags, 0);
        chk("evt_vld after reset", evt_vld, 0);
        rst_n = 1'b1;

        // R2: high from reset is not an event; staying high gives none
        cur_req = "R2";
        step(4'b1111, 1, 0);
        step(4'b1111, 1, 0);
        // R2: from high, a rise after a low inside the period counts (phase 1)
        step(4'b1110, 1, 0);
        step(4'b0000, 1, 0);

        // R1 and R3: each phase from low, monitoring on
        cur_req = "R1";
        step(4'b1111, 1, 0); step(4'b0000, 1, 0);   // phase 4
        step(4'b1110, 1, 0); step(4'b0000, 1, 0);   // phase 1
        step(4'b1100, 1, 0); step(4'b0000, 1, 0);   // phase 2
        step(4'b1000, 1, 0); step(4'b0000, 1, 0);   // phase 3

        // R2: two pulses inside one period give one event
        cur_req = "R2";
        step(4'b0101, 1, 0); step(4'b0000, 1, 0);
        step(4'b1010, 1, 0); step(4'b0000, 1, 0);

        // R3: strobe also while monitoring off; R9: stats frozen
        cur_req = "R9";
        step(4'b1100, 0, 0); step(4'b0000, 0, 0);
        step(4'b0001, 0, 0); step(4'b0000, 0, 0);
        cur_req = "R3";
        step(4'b1000, 0, 0); step(4'b0000, 0, 0);

        // R7: window and offset combinations
        cur_req = "R7";
        for (int w = 0; w < 4; w++)
            for (int o = 0; o < 4; o++) begin
                win = 2'(w); ofs = 2'(o);
                step(4'b1100, 1, 0); step(4'b0000, 1, 0);
            end
        win = 0; ofs = 0;

        // R8: clear coinciding with an event wins
        cur_req = "R8";
        step(4'b1110, 1, 1);
        step(4'b0000, 1, 0);
        step(4'b1000, 1, 0); step(4'b0000, 1, 1);

        // R6: saturation of phase 1 and early-alignment counters
        cur_req = "R6";
        for (int k = 0; k < 262; k++) begin
            step(4'b1110, 1, 0); step(4'b0000, 1, 0);
        end
        // R10: explicit readback of each selection
        cur_req = "R10";
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i);
            #0.1;
            chk("rd_data select", rd_data, exp_rd(i));
        end
        chk("phase1 saturated", m_cnt[0], 255);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule